// File: doc/BRIEF.md
# Asynchronous SRAM Access Gate with Write Lockout

This block sits between the asynchronous control pins of a byte-wide memory (chip select, output enable, write strobe, busy line) and the memory array behind them. It samples the pins on a system clock and turns them into registered read-enable, write-enable and output-drive signals. It also holds a small behavioural byte array that those enables act on.

The block protects stored data. Writes are refused while the supply is flagged low. Reads and writes are both refused while a nonvolatile transfer is running. A write strobe that is still held low when access comes back (after reset, a transfer or a low-supply period) does nothing until the host lifts and lowers chip select or write strobe again.

Each read access that begins, or that moves to a new address, also produces a one-cycle strobe. The strobe carries the low 16 address bits so that a neighbouring command-sequence detector can follow them.

Top module: `async_access_gate`

## Requirements
- R1: A read is decoded when chip select is low, output enable is low, write strobe is high, busy is high and no transfer is running. `rd_en` shows the decode of the pins as they stood before the clock edge two edges earlier.
- R2: A write is decoded when chip select and write strobe are low, busy is high, no transfer runs, supply is not low and the lockout is clear. `wr_en` has the same two-edge latency, and the byte is stored on that edge.
- R3: `drive_en` is high only during a decoded read. It is low whenever chip select or output enable is high, or write strobe is low.
- R4: While `low_supply` is high, no write is performed and stored data is unchanged. Reads still work.
- R5: While `xfer_busy` is high, `rd_en`, `wr_en` and `drive_en` stay low.
- R6: Reset, a transfer and a low-supply period each arm a lockout. A write request still held after access resumes is suppressed until chip select or write strobe has been seen high and then low again.
- R7: `rdata` is registered. It shows the addressed byte in the same cycle `rd_en` is high, and holds it afterwards.
- R8: `rd_strobe` pulses for one cycle when a read-type access begins, or when its address changes while the access continues. A read-type access is chip select low, write strobe high, busy high and no transfer; output enable is not required. `rd_strobe_addr` then carries address bits 15:0.
- R9: While reset is high, and after it, all enables, `rd_strobe`, `rd_strobe_addr` and `rdata` are zero.
- R10: Busy low blocks reads and writes but does not arm the lockout. A write held through it takes effect once busy returns high.
- R11: The array holds 2**MEM_AW bytes. Address bits at and above MEM_AW do not select storage, so addresses that differ only there share a byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low |
| busy_n | input | 1 | Busy line, low blocks access |
| xfer_busy | input | 1 | Nonvolatile transfer running |
| low_supply | input | 1 | Supply below switch level |
| addr | input | ADDR_W | Byte address |
| wdata | input | DATA_W | Write data |
| rd_en | output | 1 | Registered read enable |
| wr_en | output | 1 | Registered write enable |
| drive_en | output | 1 | Output driver enable |
| rdata | output | DATA_W | Registered read data |
| rd_strobe | output | 1 | One-cycle read-access pulse |
| rd_strobe_addr | output | CMD_AW | Low address bits of the last strobe |

## Verification
On every cycle the assertions check three things. Reads and writes never overlap. A transfer, low supply or busy low in the sampled pins blocks the matching enable. A held write whose lockout is armed never reaches the array. Two things can only be shown by the bench's scenarios, where a behavioural model compared each clock judges the values. One is whether the right byte lands and comes back, including through aliased addresses. The other is whether the lockout releases on exactly the re-strobe, and whether strobes appear once per new read address.

// File: rtl/gate_pkg.sv
package gate_pkg;
  typedef struct packed {
    logic ce_n;
    logic oe_n;
    logic we_n;
    logic busy_n;
    logic xfer;
    logic low;
  } pins_t;

  localparam pins_t PINS_IDLE = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1,
                                  busy_n: 1'b1, xfer: 1'b0, low: 1'b0};
endpackage

// File: rtl/pin_sampler.sv
module pin_sampler
  import gate_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  pins_t             pins_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output pins_t             pins_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] data_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pins_q <= PINS_IDLE;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      pins_q <= pins_i;
      addr_q <= addr_i;
      data_q <= data_i;
    end
  end
endmodule

// File: rtl/access_decoder.sv
module access_decoder
  import gate_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int CMD_AW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  pins_t             s,
  input  logic [ADDR_W-1:0] addr_s,
  output logic              rd_en,
  output logic              wr_en,
  output logic              drive_en,
  output logic              rd_strobe,
  output logic [CMD_AW-1:0] rd_strobe_addr
);
  logic lock_q;
  logic acc_q;
  logic [ADDR_W-1:0] addr_prev_q;

  logic blocked, wr_req, rd_d, wr_d, acc_d, fresh_d;

  always_comb begin
    blocked = s.xfer | s.low;
    wr_req  = ~s.ce_n & ~s.we_n;
    rd_d    = ~s.ce_n & ~s.oe_n & s.we_n & s.busy_n & ~s.xfer;
    wr_d    = wr_req & s.busy_n & ~s.xfer & ~s.low & ~lock_q;
    acc_d   = ~s.ce_n & s.we_n & s.busy_n & ~s.xfer;
    fresh_d = acc_d & ~(acc_q && (addr_s == addr_prev_q));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q         <= 1'b1;
      acc_q          <= 1'b0;
      addr_prev_q    <= '0;
      rd_en          <= 1'b0;
      wr_en          <= 1'b0;
      drive_en       <= 1'b0;
      rd_strobe      <= 1'b0;
      rd_strobe_addr <= '0;
    end else begin
      if (blocked)      lock_q <= 1'b1;
      else if (!wr_req) lock_q <= 1'b0;
      acc_q       <= acc_d;
      addr_prev_q <= addr_s;
      rd_en       <= rd_d;
      wr_en       <= wr_d;
      drive_en    <= rd_d;
      rd_strobe   <= fresh_d;
      if (fresh_d) rd_strobe_addr <= addr_s[CMD_AW-1:0];
    end
  end

  assert_rd_wr_excl_R1: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && wr_en));
  assert_drive_off_R3: assert property (@(posedge clk) disable iff (rst)
    (s.ce_n || s.oe_n || !s.we_n) |=> !drive_en);
  assert_no_wr_low_R4: assert property (@(posedge clk) disable iff (rst)
    s.low |=> !wr_en);
  assert_xfer_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    s.xfer |=> !(rd_en || wr_en || drive_en));
  assert_lock_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (lock_q && wr_req) |=> !wr_en);
  assert_strobe_new_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe && $past(rd_strobe)) |-> (rd_strobe_addr != $past(rd_strobe_addr)
      || $past(addr_s, 2) != $past(addr_s, 3)));
  assert_busy_block_R10: assert property (@(posedge clk) disable iff (rst)
    !s.busy_n |=> !(rd_en || wr_en));
endmodule

// File: rtl/byte_array.sv
module byte_array #(
  parameter int MEM_AW = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              re,
  input  logic [MEM_AW-1:0] a,
  input  logic [DATA_W-1:0] wd,
  output logic [DATA_W-1:0] rd
);
  localparam int DEPTH = 1 << MEM_AW;
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[a] <= wd;
  end

  always_ff @(posedge clk) begin
    if (rst)     rd <= '0;
    else if (re) rd <= mem[a];
  end
endmodule

// File: rtl/async_access_gate.sv
module async_access_gate
  import gate_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8,
  parameter int MEM_AW = 10,
  parameter int CMD_AW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              busy_n,
  input  logic              xfer_busy,
  input  logic              low_supply,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              rd_en,
  output logic              wr_en,
  output logic              drive_en,
  output logic [DATA_W-1:0] rdata,
  output logic              rd_strobe,
  output logic [CMD_AW-1:0] rd_strobe_addr
);
  localparam int IDX_W = (MEM_AW < ADDR_W) ? MEM_AW : ADDR_W;

  pins_t pins_in, pins_s;
  logic [ADDR_W-1:0] addr_s;
  logic [DATA_W-1:0] data_s;
  logic rd_d_s, wr_d_s;

  assign pins_in = '{ce_n: ce_n, oe_n: oe_n, we_n: we_n, busy_n: busy_n,
                     xfer: xfer_busy, low: low_supply};

  pin_sampler #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sampler (
    .clk(clk), .rst(rst), .pins_i(pins_in), .addr_i(addr), .data_i(wdata),
    .pins_q(pins_s), .addr_q(addr_s), .data_q(data_s)
  );

  access_decoder #(.ADDR_W(ADDR_W), .CMD_AW(CMD_AW)) u_decoder (
    .clk(clk), .rst(rst), .s(pins_s), .addr_s(addr_s),
    .rd_en(rd_en), .wr_en(wr_en), .drive_en(drive_en),
    .rd_strobe(rd_strobe), .rd_strobe_addr(rd_strobe_addr)
  );

  // The array acts on the same edge that registers the enables.
  always_comb begin
    rd_d_s = ~pins_s.ce_n & ~pins_s.oe_n & pins_s.we_n & pins_s.busy_n & ~pins_s.xfer;
    wr_d_s = ~pins_s.ce_n & ~pins_s.we_n & pins_s.busy_n & ~pins_s.xfer
           & ~pins_s.low & ~u_decoder.lock_q;
  end

  byte_array #(.MEM_AW(IDX_W), .DATA_W(DATA_W)) u_array (
    .clk(clk), .rst(rst), .we(wr_d_s), .re(rd_d_s),
    .a(addr_s[IDX_W-1:0]), .wd(data_s), .rd(rdata)
  );

  assert_wr_lat_R2: assert property (@(posedge clk) disable iff (rst)
    wr_d_s |=> wr_en);
  assert_rdata_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!rd_en && $past(!rd_en)) |-> $stable(rdata));
endmodule

// File: tb/async_access_gate_tb.sv
module async_access_gate_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 17;
  localparam int MAW = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce_n = 1, oe_n = 1, we_n = 1, busy_n = 1, xfer_busy = 0, low_supply = 0;
  logic [AW-1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic rd_en, wr_en, drive_en, rd_strobe;
  logic [7:0] rdata;
  logic [15:0] rd_strobe_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  async_access_gate #(.ADDR_W(AW), .DATA_W(8), .MEM_AW(MAW), .CMD_AW(16)) u_dut (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .busy_n(busy_n),
    .xfer_busy(xfer_busy), .low_supply(low_supply), .addr(addr), .wdata(wdata),
    .rd_en(rd_en), .wr_en(wr_en), .drive_en(drive_en), .rdata(rdata),
    .rd_strobe(rd_strobe), .rd_strobe_addr(rd_strobe_addr)
  );

  int checks = 0;
  int fails = 0;
  int wr_cnt = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model, advanced on each rising edge
  logic [7:0] mem_m [1 << MAW];
  bit known_m [1 << MAW];
  bit e_rd, e_wr, e_stb, e_rknown, m_lock, m_pacc;
  logic [15:0] e_sa;
  logic [7:0] e_rdata;
  logic [AW-1:0] m_paddr, s_addr;
  logic [7:0] s_data;
  bit s_ce, s_oe, s_we, s_busy, s_xfer, s_low;
  bit wreq, acc;
  int idx;

  always @(posedge clk) begin
    if (rst) begin
      e_rd = 0; e_wr = 0; e_stb = 0; e_sa = 0; e_rdata = 0; e_rknown = 1;
      m_lock = 1; m_pacc = 0; m_paddr = 0;
      s_ce = 1; s_oe = 1; s_we = 1; s_busy = 1; s_xfer = 0; s_low = 0;
      s_addr = 0; s_data = 0;
    end else begin
      idx   = int'(s_addr) % (1 << MAW);
      wreq  = !s_ce && !s_we;
      acc   = !s_ce && s_we && s_busy && !s_xfer;
      e_rd  = acc && !s_oe;
      e_wr  = wreq && s_busy && !s_xfer && !s_low && !m_lock;
      e_stb = acc && !(m_pacc && s_addr == m_paddr);
      if (e_stb) e_sa = s_addr[15:0];
      if (e_wr) begin mem_m[idx] = s_data; known_m[idx] = 1; end
      if (e_rd) begin e_rdata = mem_m[idx]; e_rknown = known_m[idx]; end
      if (s_xfer || s_low) m_lock = 1;
      else if (!wreq) m_lock = 0;
      m_pacc = acc; m_paddr = s_addr;
      s_ce = ce_n; s_oe = oe_n; s_we = we_n; s_busy = busy_n;
      s_xfer = xfer_busy; s_low = low_supply; s_addr = addr; s_data = wdata;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      if (wr_en) wr_cnt++;
      chk(rd_en === e_rd, "R1 rd_en", rd_en, e_rd);
      chk(wr_en === e_wr, "R2 wr_en", wr_en, e_wr);
      chk(drive_en === e_rd, "R3 drive_en", drive_en, e_rd);
      chk(rd_strobe === e_stb, "R8 rd_strobe", rd_strobe, e_stb);
      chk(rd_strobe_addr === e_sa, "R8 rd_strobe_addr", rd_strobe_addr, e_sa);
      if (e_rknown) chk(rdata === e_rdata, "R7 rdata", rdata, e_rdata);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic idle();
    ce_n = 1; oe_n = 1; we_n = 1;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    addr = a; wdata = d; ce_n = 0; we_n = 0; oe_n = 1;
    step(1); idle(); step(1);
  endtask

  task automatic rd(input logic [AW-1:0] a);
    addr = a; ce_n = 0; oe_n = 0; we_n = 1;
    step(1); idle(); step(2);
  endtask

  initial begin
    int base;
    step(3);
    chk(rd_en === 0 && wr_en === 0 && drive_en === 0 && rd_strobe === 0, "R9 reset enables",
        {rd_en, wr_en, drive_en, rd_strobe}, 0);
    chk(rdata === 0 && rd_strobe_addr === 0, "R9 reset data", rdata, 0);
    rst = 0; step(2);
    chk(rd_en === 0 && rdata === 0, "R9 after reset", rdata, 0);

    // basic writes and reads (R1 R2 R7)
    wr(17'h00005, 8'h12); wr(17'h00006, 8'h34); wr(17'h003FF, 8'h5A);
    rd(17'h00005); chk(rdata === 8'h12, "R7 read back 5", rdata, 8'h12);
    rd(17'h003FF); chk(rdata === 8'h5A, "R7 read back 3FF", rdata, 8'h5A);

    // held chip select, moving address: one strobe per address (R8)
    ce_n = 0; oe_n = 0; we_n = 1; addr = 17'h04E38; step(2);
    addr = 17'h0B1C7; step(1); addr = 17'h00006; step(3); idle(); step(2);
    chk(rd_strobe_addr === 16'h0006, "R8 last strobe addr", rd_strobe_addr, 16'h0006);
    // output enable high still strobes, no drive (R3 R8)
    ce_n = 0; oe_n = 1; we_n = 1; addr = 17'h08FC0; step(3);
    chk(drive_en === 0 && rd_en === 0, "R3 oe high no drive", drive_en, 0);
    idle(); step(2);
    chk(rd_strobe_addr === 16'h8FC0, "R8 strobe without oe", rd_strobe_addr, 16'h8FC0);

    // low supply blocks writes, reads still work (R4)
    base = wr_cnt;
    low_supply = 1; wr(17'h00005, 8'h99); rd(17'h00006);
    chk(rdata === 8'h34, "R4 read under low supply", rdata, 8'h34);
    low_supply = 0; step(1);
    chk(wr_cnt == base, "R4 no write count", wr_cnt, base);
    rd(17'h00005); chk(rdata === 8'h12, "R4 data kept", rdata, 8'h12);

    // transfer blocks read (R5)
    xfer_busy = 1; ce_n = 0; oe_n = 0; we_n = 1; addr = 17'h00005; step(4);
    chk(rd_en === 0 && drive_en === 0, "R5 read blocked", rd_en, 0);
    idle(); step(1);

    // write held across a transfer is locked out (R6)
    base = wr_cnt;
    addr = 17'h00007; wdata = 8'hAA; ce_n = 0; we_n = 0; oe_n = 1; step(3);
    xfer_busy = 0; step(5);
    chk(wr_cnt == base, "R6 held write suppressed", wr_cnt, base);
    we_n = 1; step(1); we_n = 0; step(1); we_n = 1; ce_n = 1; step(3);
    chk(wr_cnt == base + 1, "R6 re-strobe writes", wr_cnt, base + 1);
    rd(17'h00007); chk(rdata === 8'hAA, "R6 data after re-strobe", rdata, 8'hAA);

    // held write across low supply, released by chip select toggle (R6)
    base = wr_cnt;
    low_supply = 1; addr = 17'h00008; wdata = 8'hC3; ce_n = 0; we_n = 0; step(3);
    low_supply = 0; step(4);
    chk(wr_cnt == base, "R6 lock after low supply", wr_cnt, base);
    ce_n = 1; step(1); ce_n = 0; step(1); idle(); step(3);
    chk(wr_cnt == base + 1, "R6 ce toggle releases", wr_cnt, base + 1);

    // busy low blocks but does not lock (R10)
    base = wr_cnt;
    busy_n = 0; rd(17'h00005);
    chk(rd_en === 0, "R10 read blocked by busy", rd_en, 0);
    addr = 17'h00009; wdata = 8'h3C; ce_n = 0; we_n = 0; step(3);
    chk(wr_cnt == base, "R10 write blocked by busy", wr_cnt, base);
    busy_n = 1; step(1); idle(); step(3);
    chk(wr_cnt == base + 1, "R10 write after busy release", wr_cnt, base + 1);
    rd(17'h00009); chk(rdata === 8'h3C, "R10 read back", rdata, 8'h3C);

    // upper address bits alias (R11)
    wr(17'h10405, 8'h77); rd(17'h00005);
    chk(rdata === 8'h77, "R11 alias shares byte", rdata, 8'h77);

    step(2);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule